// File: doc/BRIEF.md
# SPI Slave Command Frame Validator

This block sits behind the byte deserialiser of an SPI slave. It sees every byte the master clocks in while slave select is low, frames each command, and decides what the slave shifts out on the next byte exchange. Two-byte query commands (protocol version and readiness status) are answered locally. Payload commands are streamed to a downstream consumer byte by byte and closed with an end marker that says whether the frame was well formed. Malformed traffic is caught, and the first fault is held until it can be reported.

A fault found in one transaction is reported in the next one. That next command is still framed (lead byte, length, terminator) but it is thrown away, and the slave answers with a three-byte error reply: code, error byte, terminator. After the block leaves reset the same path delivers a reset notice (code 0x00 plus a static reset-type byte), whatever command the master sends first. Outside a reply the slave always shifts out 0xFF.

The forward port has no ready input. An SPI slave cannot stall the master, so the consumer must take one beat on every cycle in which `fwd_valid` is high. The block holds no buffer for stalled beats. `tx_byte` is the byte to load into the shifter for the next exchange. It changes only on a received-byte strobe or when slave select is high.

Top module: `fv_cmd_validator`

## Requirements
- R1: `tx_byte` is 0xFF after reset, while slave select is high, and at every point outside a reply. Bytes received after a command has been rejected or completed in the same transaction are ignored.
- R2: If slave select is low when reset ends, every strobe is ignored until slave select has been high at least once. During that time nothing is forwarded and no reply starts.
- R3: Command 0x0A followed by terminator 0xA7 is answered with {2'b10, PROTO_VER[5:0]} (0x82 by default) and then 0xA7.
- R4: Command 0x0B followed by 0xA7 is answered with {2'b11, 5'b0, core_ready} and then 0xA7. `core_ready` is sampled with the lead byte.
- R5: A command led by 0xFD or 0xFE forwards the lead byte (with `fwd_first`), the length byte and the payload bytes, one beat per strobe, one cycle after each strobe. A correct 0xA7 after the payload gives a one-cycle `fwd_end` with `fwd_ok`=1. While the frame is received, `tx_byte` stays 0xFF.
- R6: A lead byte other than 0x0A, 0x0B, 0xFD or 0xFE latches error code 0x04.
- R7: A length byte above 133 latches code 0x01, and a frame that was being forwarded ends with `fwd_ok`=0. A length of exactly 133 is accepted.
- R8: A byte other than 0xA7 in the terminator position latches code 0x03, and a forwarded frame ends with `fwd_ok`=0.
- R9: Slave select rising after the lead byte but before the terminator latches code 0x02, and a forwarded frame ends with `fwd_ok`=0.
- R10: After reset, and after a pulse on `boot_evt`, a reset notice is pending. It is reported as 0x00, `reset_kind`, 0xA7.
- R11: While an error is pending, the next command is framed but not forwarded, and the reply is code, error byte (0x00 for codes 0x01 to 0x04), 0xA7. Only the first error is latched. It is cleared only when its whole reply has been shifted out.
- R12: Slave select going high always restarts framing, so the next strobe is taken as a lead byte, even if a reply was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Slave select, active low, synchronous to clk |
| rx_valid | input | 1 | One-cycle strobe: a byte exchange completed |
| rx_byte | input | 8 | Byte received from the master |
| boot_evt | input | 1 | Pulse: device restarted, queue a reset notice |
| reset_kind | input | 8 | Static reset-type byte used in the reset notice |
| core_ready | input | 1 | Readiness bit reported by the status query |
| tx_byte | output | 8 | Byte to shift out on the next exchange |
| fwd_valid | output | 1 | Forward beat valid |
| fwd_byte | output | 8 | Forward beat data |
| fwd_first | output | 1 | Beat is the lead byte of a frame |
| fwd_end | output | 1 | One-cycle frame close marker |
| fwd_ok | output | 1 | Frame closed with a valid terminator (meaningful with fwd_end) |

## Verification
A framing counter that has drifted shows on the very next strobe: the terminator lands in the wrong position, and a wrong error code appears in the reply of the following transaction. A mistake in the error latch, such as a second error overwriting the first or an early clear, shows only one transaction later, as the wrong code or a missing reply. For that reason the bench always follows a faulty transaction with a query and compares every byte shifted out. Forward beats and end markers are compared in order, so a dropped or extra beat shows within a cycle of the strobe that caused it.

// File: rtl/fv_pkg.sv
package fv_pkg;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] TERM_BYTE = 8'hA7;

  localparam logic [7:0] LEAD_VER  = 8'h0A;
  localparam logic [7:0] LEAD_STAT = 8'h0B;
  localparam logic [7:0] LEAD_BOOT = 8'hFD;
  localparam logic [7:0] LEAD_APP  = 8'hFE;

  localparam logic [7:0] CODE_RESET    = 8'h00;
  localparam logic [7:0] CODE_OVERSIZE = 8'h01;
  localparam logic [7:0] CODE_ABORT    = 8'h02;
  localparam logic [7:0] CODE_NOTERM   = 8'h03;
  localparam logic [7:0] CODE_UNSUP    = 8'h04;

  typedef enum logic [2:0] {
    PH_LEAD, PH_LEN, PH_BODY, PH_TERM, PH_RESP, PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    LC_VERSION, LC_STATUS, LC_FRAME, LC_BAD
  } lead_t;
endpackage

// File: rtl/fv_lead_class.sv
module fv_lead_class
  import fv_pkg::*;
(
  input  logic [7:0] lead_byte,
  output lead_t      lead_cls
);
  always_comb begin
    case (lead_byte)
      LEAD_VER:            lead_cls = LC_VERSION;
      LEAD_STAT:           lead_cls = LC_STATUS;
      LEAD_BOOT, LEAD_APP: lead_cls = LC_FRAME;
      default:             lead_cls = LC_BAD;
    endcase
  end
endmodule

// File: rtl/fv_err_latch.sv
module fv_err_latch
  import fv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_evt,
  input  logic       set_req,
  input  logic [7:0] set_code,
  input  logic       clear,
  input  logic [7:0] reset_kind,
  output logic       pend,
  output logic [7:0] code,
  output logic [7:0] aux
);
  logic       pend_q;
  logic [7:0] code_q;
  logic       is_rst_q;
  logic       free;

  // the slot accepts a new error only when empty or being emptied
  assign free = !pend_q || clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b1;
      code_q   <= CODE_RESET;
      is_rst_q <= 1'b1;
    end else if (free && boot_evt) begin
      pend_q   <= 1'b1;
      code_q   <= CODE_RESET;
      is_rst_q <= 1'b1;
    end else if (free && set_req) begin
      pend_q   <= 1'b1;
      code_q   <= set_code;
      is_rst_q <= 1'b0;
    end else if (clear) begin
      pend_q   <= 1'b0;
    end
  end

  assign pend = pend_q;
  assign code = code_q;
  assign aux  = is_rst_q ? reset_kind : 8'h00;
endmodule

// File: rtl/fv_resp_seq.sv
module fv_resp_seq
  import fv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] first_b,
  input  logic [7:0] second_b,
  input  logic       three,
  input  logic       step,
  input  logic       kill,
  output logic [7:0] tx_byte,
  output logic       active,
  output logic       finishing
);
  logic [7:0] tx_q;
  logic [7:0] sec_q;
  logic       three_q;
  logic       act_q;
  logic [1:0] idx_q;
  logic [1:0] last_idx;

  assign last_idx  = three_q ? 2'd3 : 2'd2;
  assign finishing = step && act_q && (idx_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= FILL_BYTE;
      sec_q   <= 8'h00;
      three_q <= 1'b0;
      act_q   <= 1'b0;
      idx_q   <= 2'd0;
    end else if (kill) begin
      tx_q  <= FILL_BYTE;
      act_q <= 1'b0;
    end else if (load) begin
      tx_q    <= first_b;
      sec_q   <= second_b;
      three_q <= three;
      act_q   <= 1'b1;
      idx_q   <= 2'd1;
    end else if (step && act_q) begin
      if (finishing) begin
        tx_q  <= FILL_BYTE;
        act_q <= 1'b0;
      end else begin
        tx_q  <= (three_q && idx_q == 2'd1) ? sec_q : TERM_BYTE;
        idx_q <= idx_q + 2'd1;
      end
    end
  end

  assign tx_byte = tx_q;
  assign active  = act_q;
endmodule

// File: rtl/fv_cmd_validator.sv
module fv_cmd_validator
  import fv_pkg::*;
#(
  parameter int PROTO_VER = 2,
  parameter int MAX_LEN   = 133
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ss_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       boot_evt,
  input  logic [7:0] reset_kind,
  input  logic       core_ready,
  output logic [7:0] tx_byte,
  output logic       fwd_valid,
  output logic [7:0] fwd_byte,
  output logic       fwd_first,
  output logic       fwd_end,
  output logic       fwd_ok
);
  localparam logic [7:0] VER_REPLY = {2'b10, 6'(PROTO_VER)};
  localparam logic [7:0] LEN_LIMIT = 8'(MAX_LEN);

  phase_t     ph_q, ph_n;
  logic       armed_q;
  logic       drop_q, drop_n;
  logic       frame_q, frame_n;
  logic [7:0] cnt_q, cnt_n;
  logic [7:0] qry_q, qry_n;

  logic       strobe;
  lead_t      lead_cls;
  logic       err_pend;
  logic [7:0] err_code, err_aux;
  logic       err_set;
  logic [7:0] err_new;
  logic       rsp_load, rsp_three, rsp_active, rsp_fin;
  logic [7:0] rsp_b0, rsp_b1;
  logic       fv_n, ff_n, fe_n, fok_n;
  logic       mid_frame;

  assign strobe    = rx_valid && !ss_n && armed_q;
  assign mid_frame = (ph_q == PH_LEN) || (ph_q == PH_BODY) || (ph_q == PH_TERM);

  fv_lead_class u_cls (
    .lead_byte (rx_byte),
    .lead_cls  (lead_cls)
  );

  fv_err_latch u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_evt   (boot_evt),
    .set_req    (err_set),
    .set_code   (err_new),
    .clear      (rsp_fin && drop_q),
    .reset_kind (reset_kind),
    .pend       (err_pend),
    .code       (err_code),
    .aux        (err_aux)
  );

  fv_resp_seq u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rsp_load),
    .first_b   (rsp_b0),
    .second_b  (rsp_b1),
    .three     (rsp_three),
    .step      (strobe && ph_q == PH_RESP),
    .kill      (ss_n),
    .tx_byte   (tx_byte),
    .active    (rsp_active),
    .finishing (rsp_fin)
  );

  always_comb begin
    ph_n      = ph_q;
    drop_n    = drop_q;
    frame_n   = frame_q;
    cnt_n     = cnt_q;
    qry_n     = qry_q;
    err_set   = 1'b0;
    err_new   = CODE_UNSUP;
    rsp_load  = 1'b0;
    rsp_b0    = err_code;
    rsp_b1    = err_aux;
    rsp_three = 1'b1;
    fv_n      = 1'b0;
    ff_n      = 1'b0;
    fe_n      = 1'b0;
    fok_n     = 1'b0;
    if (ss_n) begin
      ph_n    = PH_LEAD;
      drop_n  = 1'b0;
      frame_n = 1'b0;
      if (armed_q && mid_frame && !drop_q) begin
        err_set = 1'b1;
        err_new = CODE_ABORT;
        fe_n    = frame_q;
      end
    end else if (strobe) begin
      case (ph_q)
        PH_LEAD: begin
          drop_n = err_pend;
          case (lead_cls)
            LC_VERSION: begin
              qry_n = VER_REPLY;
              ph_n  = PH_TERM;
            end
            LC_STATUS: begin
              qry_n = {2'b11, 5'b00000, core_ready};
              ph_n  = PH_TERM;
            end
            LC_FRAME: begin
              ph_n = PH_LEN;
              if (!err_pend) begin
                frame_n = 1'b1;
                fv_n    = 1'b1;
                ff_n    = 1'b1;
              end
            end
            default: begin
              if (err_pend) begin
                rsp_load = 1'b1;
                ph_n     = PH_RESP;
              end else begin
                err_set = 1'b1;
                err_new = CODE_UNSUP;
                ph_n    = PH_SKIP;
              end
            end
          endcase
        end
        PH_LEN: begin
          if (rx_byte > LEN_LIMIT) begin
            if (drop_q) begin
              rsp_load = 1'b1;
              ph_n     = PH_RESP;
            end else begin
              err_set = 1'b1;
              err_new = CODE_OVERSIZE;
              fe_n    = frame_q;
              frame_n = 1'b0;
              ph_n    = PH_SKIP;
            end
          end else begin
            fv_n  = frame_q;
            cnt_n = rx_byte;
            ph_n  = (rx_byte == 8'h00) ? PH_TERM : PH_BODY;
          end
        end
        PH_BODY: begin
          fv_n  = frame_q;
          cnt_n = cnt_q - 8'd1;
          if (cnt_q == 8'd1) ph_n = PH_TERM;
        end
        PH_TERM: begin
          frame_n = 1'b0;
          if (drop_q) begin
            rsp_load = 1'b1;
            ph_n     = PH_RESP;
          end else if (rx_byte == TERM_BYTE) begin
            if (frame_q) begin
              fe_n  = 1'b1;
              fok_n = 1'b1;
              ph_n  = PH_SKIP;
            end else begin
              rsp_load  = 1'b1;
              rsp_b0    = qry_q;
              rsp_three = 1'b0;
              ph_n      = PH_RESP;
            end
          end else begin
            err_set = 1'b1;
            err_new = CODE_NOTERM;
            fe_n    = frame_q;
            ph_n    = PH_SKIP;
          end
        end
        PH_RESP: begin
          if (rsp_fin || !rsp_active) ph_n = PH_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_LEAD;
      armed_q   <= 1'b0;
      drop_q    <= 1'b0;
      frame_q   <= 1'b0;
      cnt_q     <= 8'h00;
      qry_q     <= 8'h00;
      fwd_valid <= 1'b0;
      fwd_byte  <= 8'h00;
      fwd_first <= 1'b0;
      fwd_end   <= 1'b0;
      fwd_ok    <= 1'b0;
    end else begin
      ph_q      <= ph_n;
      armed_q   <= armed_q || ss_n;
      drop_q    <= drop_n;
      frame_q   <= frame_n;
      cnt_q     <= cnt_n;
      qry_q     <= qry_n;
      fwd_valid <= fv_n;
      fwd_byte  <= rx_byte;
      fwd_first <= ff_n;
      fwd_end   <= fe_n;
      fwd_ok    <= fok_n;
    end
  end
endmodule

// File: rtl/fv_cmd_validator_chk.sv
module fv_cmd_validator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ss_n,
  input logic       rx_valid,
  input logic [7:0] tx_byte,
  input logic       fwd_valid,
  input logic       fwd_end
);
  logic seen_high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_high_q <= 1'b0;
    else if (ss_n) seen_high_q <= 1'b1;
  end

  AST_FILL_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |=> tx_byte == 8'hFF); // R1

  AST_TX_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !ss_n) |=> $stable(tx_byte)); // R1

  AST_QUIET_UNTIL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_high_q |-> (tx_byte == 8'hFF && !fwd_valid)); // R2

  AST_FWD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ($past(rx_valid) && !$past(ss_n))); // R5

  AST_END_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_end |=> !fwd_end); // R5
endmodule

bind fv_cmd_validator fv_cmd_validator_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ss_n      (ss_n),
  .rx_valid  (rx_valid),
  .tx_byte   (tx_byte),
  .fwd_valid (fwd_valid),
  .fwd_end   (fwd_end)
);

// File: tb/sim_fv_cmd_validator.sv
`timescale 1ns/1ps
module sim_fv_cmd_validator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ss_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       boot_evt = 1'b0;
  logic [7:0] reset_kind = 8'h06;
  logic       core_ready = 1'b1;
  logic [7:0] tx_byte;
  logic       fwd_valid;
  logic [7:0] fwd_byte;
  logic       fwd_first;
  logic       fwd_end;
  logic       fwd_ok;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] q_tx[$];
  string      q_tx_tag[$];
  logic [8:0] q_fwd[$];
  string      q_fwd_tag[$];
  logic       q_end[$];
  string      q_end_tag[$];

  always #5 clk = ~clk;

  fv_cmd_validator u0 (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .boot_evt(boot_evt), .reset_kind(reset_kind), .core_ready(core_ready),
    .tx_byte(tx_byte), .fwd_valid(fwd_valid), .fwd_byte(fwd_byte),
    .fwd_first(fwd_first), .fwd_end(fwd_end), .fwd_ok(fwd_ok)
  );

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares outputs against the scoreboard queues
  always @(negedge clk) begin
    #2;
    if (rx_valid) begin
      if (q_tx.size() == 0) check(9'h1FF, 9'h000, "R1 unexpected exchange");
      else check({1'b0, tx_byte}, {1'b0, q_tx.pop_front()}, q_tx_tag.pop_front());
    end
    if (fwd_valid) begin
      if (q_fwd.size() == 0) check({fwd_first, fwd_byte}, 9'h1FF, "R11 unexpected forward beat");
      else check({fwd_first, fwd_byte}, q_fwd.pop_front(), q_fwd_tag.pop_front());
    end
    if (fwd_end) begin
      if (q_end.size() == 0) check({8'h0, fwd_ok}, 9'h1FF, "R5 unexpected frame end");
      else check({8'h0, fwd_ok}, {8'h0, q_end.pop_front()}, q_end_tag.pop_front());
    end
  end

  task automatic xfer(input logic [7:0] mosi, input logic [7:0] miso, input string tag);
    q_tx.push_back(miso);
    q_tx_tag.push_back(tag);
    @(negedge clk);
    rx_valid <= 1'b1;
    rx_byte  <= mosi;
    @(negedge clk);
    rx_valid <= 1'b0;
  endtask

  task automatic exp_fwd(input logic first, input logic [7:0] b, input string tag);
    q_fwd.push_back({first, b});
    q_fwd_tag.push_back(tag);
  endtask

  task automatic exp_end(input logic ok, input string tag);
    q_end.push_back(ok);
    q_end_tag.push_back(tag);
  endtask

  task automatic sel();
    @(negedge clk);
    ss_n <= 1'b0;
    @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk);
    ss_n <= 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // two-byte query followed by polling for its two-byte reply
  task automatic query(input logic [7:0] lead, input logic [7:0] reply, input string tag);
    sel();
    xfer(lead, 8'hFF, tag);
    xfer(8'hA7, 8'hFF, tag);
    xfer(8'hFF, reply, tag);
    xfer(8'hFF, 8'hA7, tag);
    xfer(8'hFF, 8'hFF, "R1");
    desel();
  endtask

  // any command sent while an error is pending: three-byte error reply
  task automatic err_reply(input logic [7:0] code, input logic [7:0] aux, input string tag);
    sel();
    xfer(8'h0A, 8'hFF, tag);
    xfer(8'hA7, 8'hFF, tag);
    xfer(8'hFF, code, tag);
    xfer(8'hFF, aux, tag);
    xfer(8'hFF, 8'hA7, tag);
    xfer(8'hFF, 8'hFF, "R1");
    desel();
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    check({1'b0, tx_byte}, 9'h0FF, "R1 reset fill");
    check({8'h0, fwd_valid}, 9'h000, "R1 reset no forward");

    // R2: select already low out of reset, traffic must be ignored
    xfer(8'h0A, 8'hFF, "R2");
    xfer(8'hA7, 8'hFF, "R2");
    xfer(8'hFF, 8'hFF, "R2");
    xfer(8'hFF, 8'hFF, "R2");
    desel();

    // R10: first command after reset gets reset notice
    sel();
    xfer(8'h0B, 8'hFF, "R10");
    xfer(8'hA7, 8'hFF, "R10");
    xfer(8'hFF, 8'h00, "R10");
    xfer(8'hFF, 8'h06, "R10");
    xfer(8'hFF, 8'hA7, "R10");
    xfer(8'hFF, 8'hFF, "R1");
    desel();

    query(8'h0A, 8'h82, "R3");
    core_ready = 1'b1;
    query(8'h0B, 8'hC1, "R4 ready");
    core_ready = 1'b0;
    query(8'h0B, 8'hC0, "R4 not ready");

    // R5: good payload frame
    sel();
    exp_fwd(1'b1, 8'hFE, "R5"); xfer(8'hFE, 8'hFF, "R5");
    exp_fwd(1'b0, 8'h03, "R5"); xfer(8'h03, 8'hFF, "R5");
    exp_fwd(1'b0, 8'h11, "R5"); xfer(8'h11, 8'hFF, "R5");
    exp_fwd(1'b0, 8'h22, "R5"); xfer(8'h22, 8'hFF, "R5");
    exp_fwd(1'b0, 8'h33, "R5"); xfer(8'h33, 8'hFF, "R5");
    exp_end(1'b1, "R5");        xfer(8'hA7, 8'hFF, "R5");
    xfer(8'hFF, 8'hFF, "R1");
    desel();

    // R7 boundary: length 133 accepted
    sel();
    exp_fwd(1'b1, 8'hFD, "R7"); xfer(8'hFD, 8'hFF, "R7");
    exp_fwd(1'b0, 8'd133, "R7"); xfer(8'd133, 8'hFF, "R7");
    for (int i = 0; i < 133; i++) begin
      exp_fwd(1'b0, 8'(i + 5), "R7");
      xfer(8'(i + 5), 8'hFF, "R7");
    end
    exp_end(1'b1, "R7"); xfer(8'hA7, 8'hFF, "R7");
    desel();

    // R6: unsupported lead, then dropped frame gets the error reply (R11)
    sel();
    xfer(8'h55, 8'hFF, "R6");
    xfer(8'hA7, 8'hFF, "R1");
    desel();
    sel();
    xfer(8'hFE, 8'hFF, "R11");
    xfer(8'h03, 8'hFF, "R11");
    xfer(8'h01, 8'hFF, "R11");
    xfer(8'h02, 8'hFF, "R11");
    xfer(8'h03, 8'hFF, "R11");
    xfer(8'hA7, 8'hFF, "R11");
    xfer(8'hFF, 8'h04, "R6");
    xfer(8'hFF, 8'h00, "R11");
    xfer(8'hFF, 8'hA7, "R11");
    xfer(8'hFF, 8'hFF, "R1");
    desel();
    query(8'h0A, 8'h82, "R11 cleared");

    // R7: oversize length; later bytes in the transaction ignored (R1)
    sel();
    exp_fwd(1'b1, 8'hFE, "R7"); xfer(8'hFE, 8'hFF, "R7");
    exp_end(1'b0, "R7");        xfer(8'd134, 8'hFF, "R7");
    xfer(8'h0A, 8'hFF, "R1");
    xfer(8'hA7, 8'hFF, "R1");
    xfer(8'hFF, 8'hFF, "R1");
    desel();
    err_reply(8'h01, 8'h00, "R7");

    // R8: missing terminator
    sel();
    xfer(8'h0A, 8'hFF, "R8");
    xfer(8'h00, 8'hFF, "R8");
    xfer(8'hFF, 8'hFF, "R8");
    desel();
    err_reply(8'h03, 8'h00, "R8");

    // R9: aborted payload frame
    sel();
    exp_fwd(1'b1, 8'hFE, "R9"); xfer(8'hFE, 8'hFF, "R9");
    exp_fwd(1'b0, 8'h03, "R9"); xfer(8'h03, 8'hFF, "R9");
    exp_fwd(1'b0, 8'h11, "R9"); xfer(8'h11, 8'hFF, "R9");
    exp_end(1'b0, "R9");
    desel();
    err_reply(8'h02, 8'h00, "R9");

    // R11: only the first of back-to-back errors
    sel();
    xfer(8'h55, 8'hFF, "R11");
    desel();
    sel();
    xfer(8'h0A, 8'hFF, "R11");
    desel();
    err_reply(8'h04, 8'h00, "R11 first kept");
    query(8'h0A, 8'h82, "R11 no second");

    // R10: boot event queues a fresh reset notice
    @(negedge clk); boot_evt <= 1'b1;
    @(negedge clk); boot_evt <= 1'b0;
    err_reply(8'h00, 8'h06, "R10 boot");

    // R12: reply cut by deselect, next transaction reframes from lead
    sel();
    xfer(8'h0A, 8'hFF, "R12");
    xfer(8'hA7, 8'hFF, "R12");
    xfer(8'hFF, 8'h82, "R12");
    desel();
    check({1'b0, tx_byte}, 9'h0FF, "R12 fill after cut");
    query(8'h0A, 8'h82, "R12");

    repeat (4) @(negedge clk);
    check(9'(q_tx.size()), 9'd0, "R1 pending exchanges");
    check(9'(q_fwd.size()), 9'd0, "R5 pending beats");
    check(9'(q_end.size()), 9'd0, "R5 pending ends");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule